// File: doc/BRIEF.md
# RTC Alarm Match and Interrupt Unit

This block sits beside a real-time clock's timekeeping counter. It holds two independent alarm comparators. Each compares an alarm register set against the running seconds, minutes, hours, day of month, month and day of week. Every alarm byte has its own enable bit, so an alarm can watch one field, any subset of fields, or all six. The comparison is evaluated only on the one-cycle update tick that the timekeeping counter raises whenever the time changes. A match that stays true for a whole second therefore counts as one event.

Each alarm sets a sticky status flag that software clears through a clear input. The single active-low interrupt pin carries the alarm interrupt in one of two modes. In latched mode it follows the gated status flags. In pulsed mode it gives a fixed 8-cycle pulse for every match, which suits periodic hourly or daily wake-ups. A two-bit frequency select can instead route one of three square waves to the same pin. These waves are built from prescaled clock enables derived from the 32.768 kHz reference. Choosing a frequency removes the alarm from the pin.

Top module: `rtc_alarm_irq`

## Requirements
- R1: The alarm set and the time vector are both packed as six bytes: bits [7:0] second, [15:8] minute, [23:16] hour, [31:24] day, [39:32] month, [47:40] day of week. In an alarm byte, bit 7 is the field enable and bits 6:0 hold the value, laid out like the time byte. Bit 7 of a time byte is ignored.
- R2: An alarm matches when bits 6:0 of every enabled field equal those of the current time. Fields whose enable is 0 do not affect the result.
- R3: An alarm with all six field enables at 0 never matches.
- R4: Matches are evaluated only in a cycle where `tick` is 1. Equal values without `tick` have no effect.
- R5: On the clock edge that samples a matching tick, the alarm's status flag becomes 1. It stays 1 until the edge that samples its clear input high without a new match, and a match in the same cycle as a clear leaves the flag at 1.
- R6: Latched mode applies when `freq_sel`=00 and `pulse_mode`=0. In this mode `irq_n` is 0 exactly while (flag0 and `alarm0_irq_en`) or (flag1 and `alarm1_irq_en`) holds.
- R7: Pulsed mode applies when `freq_sel`=00 and `pulse_mode`=1. Each match of an alarm whose interrupt enable is 1 drives `irq_n` low for exactly 8 cycles, starting with the edge that samples the tick. A new match restarts the 8-cycle count.
- R8: An alarm whose interrupt enable is 0 never drives the pin, but its status flag still sets on a match.
- R9: `freq_sel` encodes the pin source: 00 alarm, 01 the wave stepped by `stb_32k`, 10 by `stb_4k`, 11 by `stb_1hz`. Each wave starts at 1 and toggles on every cycle its strobe is 1. With a nonzero select, `irq_n` equals the selected wave and alarm activity does not affect it.
- R10: During and after reset, the flags are 0, the pulse is idle, every wave is 1 and `irq_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle strobe marking a time update |
| now_time | input | 48 | Current time bytes, packed as in R1 |
| alarm0 | input | 48 | Alarm 0 bytes with per-field enables |
| alarm1 | input | 48 | Alarm 1 bytes with per-field enables |
| alarm0_irq_en | input | 1 | Lets alarm 0 reach the pin |
| alarm1_irq_en | input | 1 | Lets alarm 1 reach the pin |
| pulse_mode | input | 1 | 1 selects pulsed interrupts, 0 latched |
| freq_sel | input | 2 | Pin source select, encoded as in R9 |
| stb_32k | input | 1 | Toggle enable for the fastest wave |
| stb_4k | input | 1 | Toggle enable for the middle wave |
| stb_1hz | input | 1 | Toggle enable for the slowest wave |
| clr0 | input | 1 | Clears status flag 0 |
| clr1 | input | 1 | Clears status flag 1 |
| irq_n | output | 1 | Shared active-low interrupt / frequency pin |
| flag0 | output | 1 | Sticky status of alarm 0 |
| flag1 | output | 1 | Sticky status of alarm 1 |

## Verification
Several properties are checked on every cycle. Flags hold until cleared, flags rise only on a tick, and an alarm with no enabled field never sets its flag. The latched pin follows a gated flag, the pulse counter steps down one per cycle, and a frequency-driven pin changes only on its own strobe. Other behaviour needs the directed scenarios to be shown: the per-field masking with real time values, the exact 8-cycle pulse width and its restart, the set-over-clear priority, and the wave phase after a counted number of strobes.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;

    localparam int FIELD_W      = 8;
    localparam int NUM_FIELDS   = 6;
    localparam int TIME_W       = FIELD_W * NUM_FIELDS;
    localparam int VAL_W        = FIELD_W - 1;
    localparam int PULSE_CYCLES = 8;
    localparam int NUM_WAVES    = 3;

    typedef enum logic [1:0] {
        SRC_ALARM = 2'b00,
        SRC_FAST  = 2'b01,
        SRC_MID   = 2'b10,
        SRC_SLOW  = 2'b11
    } pin_src_e;

    typedef struct packed {
        logic     irq_en0;
        logic     irq_en1;
        logic     pulsed;
        pin_src_e src;
    } pin_ctrl_t;

    // wave index for a nonzero source select
    function automatic logic [1:0] wave_index(input pin_src_e s);
        return 2'(s) - 2'd1;
    endfunction

endpackage

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match
    import rtc_alarm_pkg::*;
(
    input  logic              tick,
    input  logic [TIME_W-1:0] alarm,
    input  logic [TIME_W-1:0] now_time,
    output logic              hit
);
    logic [NUM_FIELDS-1:0] fld_en;
    logic [NUM_FIELDS-1:0] fld_ok;

    for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_field
        assign fld_en[f] = alarm[f*FIELD_W + VAL_W];
        assign fld_ok[f] = !fld_en[f] ||
            (alarm[f*FIELD_W +: VAL_W] == now_time[f*FIELD_W +: VAL_W]);
    end

    assign hit = tick && (|fld_en) && (&fld_ok);
endmodule

// File: rtl/rtc_irq_pulse.sv
module rtc_irq_pulse #(
    parameter int LEN = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    output logic active
);
    localparam int CW = $clog2(LEN + 1);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)            cnt <= '0;
        else if (load)      cnt <= CW'(LEN);
        else if (cnt != '0) cnt <= cnt - 1'b1;
    end

    assign active = (cnt != '0);

    assert_pulse_step_R7: assert property (@(posedge clk) disable iff (rst)
        (active && !load) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/rtc_fout_gen.sv
module rtc_fout_gen #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] strobe,
    output logic [N-1:0] wave
);
    for (genvar i = 0; i < N; i++) begin : g_wave
        always_ff @(posedge clk) begin
            if (rst)            wave[i] <= 1'b1;
            else if (strobe[i]) wave[i] <= ~wave[i];
        end
    end
endmodule

// File: rtl/rtc_alarm_irq.sv
module rtc_alarm_irq
    import rtc_alarm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic [TIME_W-1:0] now_time,
    input  logic [TIME_W-1:0] alarm0,
    input  logic [TIME_W-1:0] alarm1,
    input  logic              alarm0_irq_en,
    input  logic              alarm1_irq_en,
    input  logic              pulse_mode,
    input  logic [1:0]        freq_sel,
    input  logic              stb_32k,
    input  logic              stb_4k,
    input  logic              stb_1hz,
    input  logic              clr0,
    input  logic              clr1,
    output logic              irq_n,
    output logic              flag0,
    output logic              flag1
);
    pin_ctrl_t             ctrl;
    logic [1:0]            hit;
    logic [1:0]            flag_q;
    logic [1:0]            clr;
    logic [NUM_WAVES-1:0]  strobes;
    logic [NUM_WAVES-1:0]  waves;
    logic                  pulse_load;
    logic                  pulse_active;
    logic                  latched_act;
    logic                  alarm_act;
    logic                  sel_strobe;
    logic                  no_en0;

    assign ctrl    = '{irq_en0: alarm0_irq_en, irq_en1: alarm1_irq_en,
                       pulsed: pulse_mode, src: pin_src_e'(freq_sel)};
    assign clr     = {clr1, clr0};
    assign strobes = {stb_1hz, stb_4k, stb_32k};

    rtc_alarm_match u_match0 (.tick(tick), .alarm(alarm0), .now_time(now_time), .hit(hit[0]));
    rtc_alarm_match u_match1 (.tick(tick), .alarm(alarm1), .now_time(now_time), .hit(hit[1]));

    for (genvar k = 0; k < 2; k++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst)         flag_q[k] <= 1'b0;
            else if (hit[k]) flag_q[k] <= 1'b1;
            else if (clr[k]) flag_q[k] <= 1'b0;
        end
    end

    assign flag0 = flag_q[0];
    assign flag1 = flag_q[1];

    assign pulse_load = (hit[0] && ctrl.irq_en0) || (hit[1] && ctrl.irq_en1);

    rtc_irq_pulse #(.LEN(PULSE_CYCLES)) u_pulse (
        .clk(clk), .rst(rst), .load(pulse_load), .active(pulse_active));

    rtc_fout_gen #(.N(NUM_WAVES)) u_fout (
        .clk(clk), .rst(rst), .strobe(strobes), .wave(waves));

    assign latched_act = (flag_q[0] && ctrl.irq_en0) || (flag_q[1] && ctrl.irq_en1);
    assign alarm_act   = ctrl.pulsed ? pulse_active : latched_act;
    assign sel_strobe  = (ctrl.src != SRC_ALARM) && strobes[wave_index(ctrl.src)];

    always_comb begin
        if (ctrl.src == SRC_ALARM) irq_n = ~alarm_act;
        else                       irq_n = waves[wave_index(ctrl.src)];
    end

    assign no_en0 = !(alarm0[7] || alarm0[15] || alarm0[23] ||
                      alarm0[31] || alarm0[39] || alarm0[47]);

    assert_flag_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (flag0 && !clr0) |=> flag0);
    assert_tick_only_R4: assert property (@(posedge clk) disable iff (rst)
        (!tick && !flag0) |=> !flag0);
    assert_no_fields_R3: assert property (@(posedge clk) disable iff (rst)
        (no_en0 && !flag0) |=> !flag0);
    assert_latched_pin_R6: assert property (@(posedge clk) disable iff (rst)
        (freq_sel == 2'b00 && !pulse_mode && flag1 && alarm1_irq_en) |-> !irq_n);
    assert_fout_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        (freq_sel != 2'b00 && !sel_strobe) |=> (!$stable(freq_sel) || $stable(irq_n)));
endmodule

// File: tb/sim_rtc_alarm_irq.sv
module sim_rtc_alarm_irq;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b0;
    logic [47:0] now_time = '0;
    logic [47:0] alarm0 = '0;
    logic [47:0] alarm1 = '0;
    logic        alarm0_irq_en = 1'b0;
    logic        alarm1_irq_en = 1'b0;
    logic        pulse_mode = 1'b0;
    logic [1:0]  freq_sel = 2'b00;
    logic        stb_32k = 1'b0;
    logic        stb_4k = 1'b0;
    logic        stb_1hz = 1'b0;
    logic        clr0 = 1'b0;
    logic        clr1 = 1'b0;
    logic        irq_n;
    logic        flag0;
    logic        flag1;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    rtc_alarm_irq u0 (.*);

    function automatic logic [47:0] pack6(input logic [7:0] sec, min, hr,
                                          day, mon, dow);
        return {dow, mon, day, hr, min, sec};
    endfunction

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0b expected %0b", req, act, exp);
        end
    endtask

    task automatic check_int(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_tick();
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic clear_both();
        clr0 = 1'b1; clr1 = 1'b1;
        @(negedge clk);
        clr0 = 1'b0; clr1 = 1'b0;
    endtask

    task automatic t_reset();
        check("R10 irq_n", irq_n, 1'b1);
        check("R10 flag0", flag0, 1'b0);
        check("R10 flag1", flag1, 1'b0);
    endtask

    task automatic t_mask_match();
        // alarm 0 watches minute 0x30 and second 0x15 only; bit 7 = enable
        alarm0 = pack6(8'h95, 8'hB0, 8'h00, 8'h00, 8'h00, 8'h00);
        now_time = pack6(8'h15, 8'h30, 8'h12, 8'h21, 8'h07, 8'h03);
        @(negedge clk);
        check("R4 no tick no flag", flag0, 1'b0);
        do_tick();
        check("R1 R2 masked match sets flag", flag0, 1'b1);
        clear_both();
        check("R5 clear", flag0, 1'b0);
        // differing enabled second field: no match
        now_time = pack6(8'h16, 8'h30, 8'h12, 8'h21, 8'h07, 8'h03);
        do_tick();
        check("R2 mismatch", flag0, 1'b0);
        // time bit 7 set must be ignored
        now_time = pack6(8'h95, 8'hB0, 8'h05, 8'h01, 8'h01, 8'h00);
        do_tick();
        check("R1 time bit7 ignored", flag0, 1'b1);
        clear_both();
    endtask

    task automatic t_no_fields();
        alarm1 = pack6(8'h15, 8'h30, 8'h12, 8'h21, 8'h07, 8'h03);
        now_time = pack6(8'h15, 8'h30, 8'h12, 8'h21, 8'h07, 8'h03);
        do_tick();
        check("R3 no enables never fires", flag1, 1'b0);
        alarm1 = pack6(8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h83);
        do_tick();
        check("R2 dow only match", flag1, 1'b1);
        clear_both();
    endtask

    task automatic t_set_over_clear();
        alarm0 = pack6(8'h80, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00);
        now_time = pack6(8'h00, 8'h11, 8'h02, 8'h03, 8'h04, 8'h05);
        clr0 = 1'b1;
        do_tick();
        clr0 = 1'b0;
        check("R5 set wins over clear", flag0, 1'b1);
        repeat (3) @(negedge clk);
        check("R5 sticky", flag0, 1'b1);
        clear_both();
    endtask

    task automatic t_latched();
        alarm0 = pack6(8'h80, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00);
        now_time = pack6(8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00);
        alarm0_irq_en = 1'b0;
        do_tick();
        check("R8 flag sets with irq disabled", flag0, 1'b1);
        check("R8 pin idle with irq disabled", irq_n, 1'b1);
        alarm0_irq_en = 1'b1;
        @(negedge clk);
        check("R6 latched pin low", irq_n, 1'b0);
        repeat (20) @(negedge clk);
        check("R6 latched pin holds", irq_n, 1'b0);
        clear_both();
        check("R6 pin released on clear", irq_n, 1'b1);
    endtask

    task automatic t_pulse();
        int low;
        pulse_mode = 1'b1;
        alarm0_irq_en = 1'b1;
        alarm0 = pack6(8'h80, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00);
        now_time = '0;
        do_tick();
        low = 0;
        for (int i = 0; i < 14; i++) begin
            if (!irq_n) low++;
            @(negedge clk);
        end
        check_int("R7 pulse width", low, 8);
        // retrigger: second match after 4 low cycles restarts count
        do_tick();
        low = 0;
        for (int i = 0; i < 3; i++) @(negedge clk);
        do_tick();
        for (int i = 0; i < 14; i++) begin
            if (!irq_n) low++;
            @(negedge clk);
        end
        check_int("R7 restart width", low, 8);
        clear_both();
        pulse_mode = 1'b0;
        alarm0_irq_en = 1'b0;
    endtask

    task automatic t_freq();
        logic [2:0] w;
        w = 3'b111;  // waves as left by reset; strobes not used before
        freq_sel = 2'b01;
        @(negedge clk);
        check("R9 fast wave start", irq_n, w[0]);
        stb_32k = 1'b1; @(negedge clk); stb_32k = 1'b0; w[0] = ~w[0];
        check("R9 fast wave toggles", irq_n, w[0]);
        stb_4k = 1'b1; @(negedge clk); stb_4k = 1'b0; w[1] = ~w[1];
        check("R9 other strobe ignored", irq_n, w[0]);
        // alarm activity is suppressed while a wave is selected
        alarm0_irq_en = 1'b1;
        alarm0 = pack6(8'h80, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00);
        now_time = '0;
        do_tick();
        check("R9 alarm suppressed", irq_n, w[0]);
        freq_sel = 2'b10;
        @(negedge clk);
        check("R9 mid wave", irq_n, w[1]);
        freq_sel = 2'b11;
        stb_1hz = 1'b1; @(negedge clk); stb_1hz = 1'b0; w[2] = ~w[2];
        stb_1hz = 1'b1; @(negedge clk); stb_1hz = 1'b0; w[2] = ~w[2];
        stb_1hz = 1'b1; @(negedge clk); stb_1hz = 1'b0; w[2] = ~w[2];
        check("R9 slow wave after 3 strobes", irq_n, w[2]);
        freq_sel = 2'b00;
        @(negedge clk);
        check("R6 alarm back on pin", irq_n, 1'b0);
        clear_both();
        alarm0_irq_en = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_mask_match();
        t_no_fields();
        t_set_over_clear();
        t_latched();
        t_pulse();
        t_freq();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual hung expected finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule